// File: doc/BRIEF.md
# SD Host Single-Address DMA Engine with Boundary Pausing

This block produces the system-memory addresses for the simple single-address DMA mode of an SD host controller. Software programs a start address, a block length and a block count, then pulses a start input. The engine issues one word-sized memory request per beat and advances the address by four bytes each time a beat is accepted. It counts words within each block and counts down blocks until the transfer is finished.

Software also sets a power-of-two buffer boundary. When the running address steps across that boundary, the engine stops before the next memory access and raises a sticky DMA interrupt. Any write to the system-address register restarts the transfer from the written value. Writing back the value read from that register continues exactly where the transfer stopped. This lets software move the buffer window one boundary-sized chunk at a time.

The register block takes a word selector. The caller derives it from address bits 7:2, so the 256-byte register window aliases throughout any larger window the chip decodes for it. Each register lane is written through byte enables.

Top module: `sdma_engine`

## Requirements
- R1: After reset, busy, paused, memReq, xferDone and dmaIrq are all 0, and the status register (selector 12) reads 0.
- R2: A start pulse while idle begins a transfer when the block count (selector 1, bits 31:16) and the block length (selector 1, bits 11:0) are both nonzero. busy rises on the next cycle and memReq is presented with memAddr equal to the system address (selector 0). A start pulse with either field zero leaves the engine idle.
- R3: Each cycle in which memReq and memAck are both high is one accepted beat, and the next address is the beat address plus 4. While memReq waits without memAck, memAddr holds steady.
- R4: A block takes ceil(length/4) beats. The block count field decrements by one when the last beat of each block is accepted, and it reads 0 after the transfer ends.
- R5: The boundary is 4 KiB shifted left by selector 1 bits 14:12 (0 gives 4 KiB, 7 gives 512 KiB). When an accepted beat, other than the final one, moves the address across a boundary, the engine pauses. memReq drops, paused and dmaIrq (status bit 3) go high, and the system address reads back the next address to be accessed.
- R6: While paused, any write to the system-address register resumes the transfer from the written value. Rewriting the read-back value continues with no skipped or repeated address. Without such a write, the engine stays paused.
- R7: When the last beat of the last block is accepted, busy drops and xferDone (status bit 0) is set. No pause and no DMA interrupt follow, even if that beat crosses a boundary.
- R8: Status bits 0 and 3 are sticky and are cleared by writing 1 to them through selector 12 with byte enable 0 set. Writing 0 leaves them set.
- R9: Writes to the system-address register while memory beats are running, and writes to selector 1 while busy, are ignored.
- R10: A pulse on swReset returns the engine to idle and clears both status bits. The system address and block count keep their current values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| swReset | input | 1 | Software reset of state and status, registers kept |
| startXfer | input | 1 | Start pulse for a transfer |
| regWrEn | input | 1 | Register write strobe |
| regWordSel | input | 6 | Register word selector (address bits 7:2) |
| regByteEn | input | 4 | Byte enables for register writes |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for regWordSel |
| memReq | output | 1 | Memory beat request |
| memAddr | output | 32 | Memory beat address |
| memAck | input | 1 | Memory beat accept |
| busy | output | 1 | Transfer in progress, including pause |
| paused | output | 1 | Stopped at a buffer boundary |
| xferDone | output | 1 | Sticky transfer-complete status |
| dmaIrq | output | 1 | Sticky boundary DMA interrupt status |

## Verification
A wrong word counter or block counter shows up on the first block end. Either memAddr keeps being requested past the expected final beat, or xferDone rises early, or the block-count read-back differs within one cycle of that beat. A wrong boundary shift or crossing test shows up on the beat that should, or should not, cross. The engine then pauses in the wrong place, or it drives memReq where it should be quiet, on the very next cycle. A corrupted address step is seen in memAddr on the following request.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam int LEN_W = 12;
  localparam int FIELD_LSB = 12;
  localparam int CNT_LSB = 16;
  localparam int CNT_W = 16;
  localparam int STS_DONE_BIT = 0;
  localparam int STS_DMA_BIT = 3;
  localparam logic [5:0] SEL_SYSADDR = 6'd0;
  localparam logic [5:0] SEL_BLOCK = 6'd1;
  localparam logic [5:0] SEL_STATUS = 6'd12;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_PAUSE = 2'd2
  } dmaState_t;

  typedef struct packed {
    logic load;
    logic beat;
    logic setDone;
    logic setIrq;
    logic addrWrOk;
    logic cfgWrOk;
  } dmaCtrl_t;
endpackage

// File: rtl/sdma_datapath.sv
module sdma_datapath
  import sdma_pkg::*;
#(
  parameter int BND_BASE_LOG2 = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        swReset,
  input  dmaCtrl_t    ctrl,
  input  logic        regWrEn,
  input  logic [5:0]  regWordSel,
  input  logic [3:0]  regByteEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic [31:0] sysAddr,
  output logic        cfgReady,
  output logic        lastBeat,
  output logic        crossNow,
  output logic        sysAddrWrHit,
  output logic        doneSts,
  output logic        irqSts
);
  localparam int WORDS_W = LEN_W - 1;

  logic [31:0] blkReg;
  logic [WORDS_W-1:0] wordsLeft;
  logic [WORDS_W-1:0] wordsPerBlk;
  logic [LEN_W:0] lenPlus;
  logic [LEN_W-1:0] blkLen;
  logic [2:0] bndField;
  logic [CNT_W-1:0] blkCnt;
  logic [31:0] nextAddr;
  logic [4:0] bndShift;
  logic blockEnd;
  logic wrSys, wrBlk, wrSts;
  logic [31:0] sysMerged, blkMerged;

  function automatic logic [31:0] mergeBytes(input logic [31:0] oldV,
                                             input logic [31:0] newV,
                                             input logic [3:0] be);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = be[i] ? newV[8*i +: 8] : oldV[8*i +: 8];
    return r;
  endfunction

  assign wrSys = regWrEn && (regWordSel == SEL_SYSADDR);
  assign wrBlk = regWrEn && (regWordSel == SEL_BLOCK);
  assign wrSts = regWrEn && (regWordSel == SEL_STATUS) && regByteEn[0];
  assign sysAddrWrHit = wrSys && (regByteEn != 4'b0000);
  assign sysMerged = mergeBytes(sysAddr, regWrData, regByteEn);
  assign blkMerged = mergeBytes(blkReg, regWrData, regByteEn);

  assign blkLen = blkReg[LEN_W-1:0];
  assign bndField = blkReg[FIELD_LSB +: 3];
  assign blkCnt = blkReg[CNT_LSB +: CNT_W];
  assign lenPlus = {1'b0, blkLen} + (LEN_W+1)'(3);
  assign wordsPerBlk = lenPlus[LEN_W:2];
  assign cfgReady = (blkLen != '0) && (blkCnt != '0);

  assign nextAddr = sysAddr + 32'd4;
  assign bndShift = 5'(BND_BASE_LOG2) + {2'b00, bndField};
  assign crossNow = ((sysAddr ^ nextAddr) >> bndShift) != 32'd0;
  assign blockEnd = (wordsLeft == WORDS_W'(1));
  assign lastBeat = blockEnd && (blkCnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sysAddr <= '0;
    else if (wrSys && ctrl.addrWrOk) sysAddr <= sysMerged;
    else if (ctrl.beat) sysAddr <= nextAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) blkReg <= '0;
    else if (wrBlk && ctrl.cfgWrOk) blkReg <= blkMerged;
    else if (ctrl.beat && blockEnd) blkReg[CNT_LSB +: CNT_W] <= blkCnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wordsLeft <= '0;
    else if (ctrl.load || (ctrl.beat && blockEnd)) wordsLeft <= wordsPerBlk;
    else if (ctrl.beat) wordsLeft <= wordsLeft - WORDS_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneSts <= 1'b0;
      irqSts <= 1'b0;
    end else if (swReset) begin
      doneSts <= 1'b0;
      irqSts <= 1'b0;
    end else begin
      if (ctrl.setDone) doneSts <= 1'b1;
      else if (wrSts && regWrData[STS_DONE_BIT]) doneSts <= 1'b0;
      if (ctrl.setIrq) irqSts <= 1'b1;
      else if (wrSts && regWrData[STS_DMA_BIT]) irqSts <= 1'b0;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regWordSel)
      SEL_SYSADDR: regRdData = sysAddr;
      SEL_BLOCK:   regRdData = blkReg;
      SEL_STATUS: begin
        regRdData[STS_DONE_BIT] = doneSts;
        regRdData[STS_DMA_BIT] = irqSts;
      end
      default: regRdData = '0;
    endcase
  end
endmodule

// File: rtl/sdma_control.sv
module sdma_control
  import sdma_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     swReset,
  input  logic     startXfer,
  input  logic     memAck,
  input  logic     cfgReady,
  input  logic     lastBeat,
  input  logic     crossNow,
  input  logic     sysAddrWrHit,
  output dmaCtrl_t ctrl,
  output logic     memReq,
  output logic     busy,
  output logic     paused
);
  dmaState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctrl = '0;
    ctrl.addrWrOk = (state != ST_RUN);
    ctrl.cfgWrOk = (state == ST_IDLE);
    memReq = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startXfer && cfgReady) begin
          ctrl.load = 1'b1;
          stateNext = ST_RUN;
        end
      end
      ST_RUN: begin
        memReq = 1'b1;
        if (memAck) begin
          ctrl.beat = 1'b1;
          if (lastBeat) begin
            ctrl.setDone = 1'b1;
            stateNext = ST_IDLE;
          end else if (crossNow) begin
            ctrl.setIrq = 1'b1;
            stateNext = ST_PAUSE;
          end
        end
      end
      ST_PAUSE: begin
        if (sysAddrWrHit) stateNext = ST_RUN;
      end
      default: stateNext = ST_IDLE;
    endcase
    if (swReset) begin
      ctrl.load = 1'b0;
      ctrl.beat = 1'b0;
      ctrl.setDone = 1'b0;
      ctrl.setIrq = 1'b0;
      stateNext = ST_IDLE;
    end
  end

  assign busy = (state != ST_IDLE);
  assign paused = (state == ST_PAUSE);
endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
  import sdma_pkg::*;
#(
  parameter int BND_BASE_LOG2 = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        swReset,
  input  logic        startXfer,
  input  logic        regWrEn,
  input  logic [5:0]  regWordSel,
  input  logic [3:0]  regByteEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        memReq,
  output logic [31:0] memAddr,
  input  logic        memAck,
  output logic        busy,
  output logic        paused,
  output logic        xferDone,
  output logic        dmaIrq
);
  dmaCtrl_t ctrlBus;
  logic [31:0] sysAddrQ;
  logic cfgReady, lastBeat, crossNow, sysAddrWrHit;

  sdma_control u_ctrl (
    .clk(clk), .rstN(rstN), .swReset(swReset), .startXfer(startXfer),
    .memAck(memAck), .cfgReady(cfgReady), .lastBeat(lastBeat),
    .crossNow(crossNow), .sysAddrWrHit(sysAddrWrHit), .ctrl(ctrlBus),
    .memReq(memReq), .busy(busy), .paused(paused)
  );

  sdma_datapath #(.BND_BASE_LOG2(BND_BASE_LOG2)) u_dp (
    .clk(clk), .rstN(rstN), .swReset(swReset), .ctrl(ctrlBus),
    .regWrEn(regWrEn), .regWordSel(regWordSel), .regByteEn(regByteEn),
    .regWrData(regWrData), .regRdData(regRdData), .sysAddr(sysAddrQ),
    .cfgReady(cfgReady), .lastBeat(lastBeat), .crossNow(crossNow),
    .sysAddrWrHit(sysAddrWrHit), .doneSts(xferDone), .irqSts(dmaIrq)
  );

  assign memAddr = sysAddrQ;
endmodule

// File: rtl/sdma_engine_chk.sv
module sdma_engine_chk (
  input logic        clk,
  input logic        rstN,
  input logic        swReset,
  input logic        memReq,
  input logic        memAck,
  input logic [31:0] memAddr,
  input logic [31:0] sysAddrQ,
  input logic        busy,
  input logic        paused,
  input logic        xferDone,
  input logic        dmaIrq
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !swReset) |=> (memReq && $stable(memAddr))); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && !swReset) |=> (sysAddrQ == $past(memAddr) + 32'd4)); // R3
  AST_PAUSE_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(paused) |-> (dmaIrq && !memReq)); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xferDone) |-> (!busy && !paused)); // R7
  AST_SWRST_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $past(swReset) |-> (!busy && !xferDone && !dmaIrq)); // R10
endmodule

bind sdma_engine sdma_engine_chk u_chk (
  .clk(clk), .rstN(rstN), .swReset(swReset), .memReq(memReq),
  .memAck(memAck), .memAddr(memAddr), .sysAddrQ(sysAddrQ), .busy(busy),
  .paused(paused), .xferDone(xferDone), .dmaIrq(dmaIrq)
);

// File: tb/sim_sdma_engine.sv
`timescale 1ns/1ps
module sim_sdma_engine;
  logic clk = 1'b0;
  logic rstN, swReset, startXfer, regWrEn, memAck;
  logic [5:0] regWordSel;
  logic [3:0] regByteEn;
  logic [31:0] regWrData, regRdData, memAddr;
  logic memReq, busy, paused, xferDone, dmaIrq;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  sdma_engine u0 (
    .clk(clk), .rstN(rstN), .swReset(swReset), .startXfer(startXfer),
    .regWrEn(regWrEn), .regWordSel(regWordSel), .regByteEn(regByteEn),
    .regWrData(regWrData), .regRdData(regRdData), .memReq(memReq),
    .memAddr(memAddr), .memAck(memAck), .busy(busy), .paused(paused),
    .xferDone(xferDone), .dmaIrq(dmaIrq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic regWr(input logic [5:0] sel, input logic [31:0] data, input logic [3:0] be);
    regWordSel = sel; regWrData = data; regByteEn = be; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRd(input logic [5:0] sel, output logic [31:0] data);
    regWordSel = sel;
    #0.5;
    data = regRdData;
  endtask

  task automatic pulseStart();
    startXfer = 1'b1;
    @(negedge clk);
    startXfer = 1'b0;
  endtask

  task automatic waitReq(input string req);
    for (int i = 0; i < 20 && !memReq; i++) @(negedge clk);
    chk(req, "memReq present", {31'b0, memReq}, 32'd1);
  endtask

  task automatic ackBeat(input int stall);
    logic [31:0] held;
    held = memAddr;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk("R3", "addr held while waiting", memAddr, held);
    end
    memAck = 1'b1;
    @(negedge clk);
    memAck = 1'b0;
  endtask

  function automatic bit crosses(input logic [31:0] a, input int field);
    logic [31:0] n;
    n = a + 32'd4;
    return ((a ^ n) >> (12 + field)) != 32'd0;
  endfunction

  task automatic runXfer(input logic [31:0] addr, input int len, input int field, input int cnt, input bit moveOnResume);
    logic [31:0] expA, nxt, rd, newA;
    int words;
    bit last;
    words = (len + 3) / 4;
    regWr(6'd0, addr, 4'hF);
    regWr(6'd1, {16'(cnt), 1'b0, 3'(field), 12'(len)}, 4'hF);
    pulseStart();
    chk("R2", "busy after start", {31'b0, busy}, 32'd1);
    expA = addr;
    for (int b = 0; b < cnt; b++) begin
      for (int w = 0; w < words; w++) begin
        waitReq("R2");
        chk("R3", "beat address", memAddr, expA);
        ackBeat($urandom % 3);
        nxt = expA + 32'd4;
        last = (b == cnt - 1) && (w == words - 1);
        if (w == words - 1) begin
          regRd(6'd1, rd);
          chk("R4", "block count after block", {16'b0, rd[31:16]}, 32'(cnt - b - 1));
        end
        if (last) begin
          chk("R7", "busy after last beat", {31'b0, busy}, 32'd0);
          chk("R7", "done set", {31'b0, xferDone}, 32'd1);
          chk("R7", "no irq at end", {31'b0, dmaIrq}, 32'd0);
        end else if (crosses(expA, field)) begin
          chk("R5", "paused at boundary", {31'b0, paused}, 32'd1);
          chk("R5", "no request while paused", {31'b0, memReq}, 32'd0);
          chk("R5", "irq at boundary", {31'b0, dmaIrq}, 32'd1);
          regRd(6'd0, rd);
          chk("R5", "readback next addr", rd, nxt);
          regWr(6'd12, 32'h0, 4'h1);
          chk("R8", "write 0 keeps irq", {31'b0, dmaIrq}, 32'd1);
          regWr(6'd12, 32'h8, 4'h1);
          chk("R8", "irq cleared by 1", {31'b0, dmaIrq}, 32'd0);
          chk("R6", "still paused without addr write", {31'b0, paused}, 32'd1);
          newA = moveOnResume ? nxt + 32'h40 : rd;
          regWr(6'd0, newA, 4'hF);
          chk("R6", "resumed", {30'b0, busy, paused}, 32'd2);
          expA = newA;
        end else begin
          expA = nxt;
        end
      end
    end
    regRd(6'd1, rd);
    chk("R4", "count zero at end", {16'b0, rd[31:16]}, 32'd0);
    regWr(6'd12, 32'h1, 4'h1);
    chk("R8", "done cleared", {31'b0, xferDone}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=finish", 100000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd20240611));
    rstN = 1'b0; swReset = 1'b0; startXfer = 1'b0; regWrEn = 1'b0; memAck = 1'b0;
    regWordSel = '0; regByteEn = '0; regWrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    chk("R1", "idle flags", {27'b0, busy, paused, memReq, xferDone, dmaIrq}, 32'd0);
    regRd(6'd12, rd);
    chk("R1", "status reads 0", rd, 32'd0);

    regWr(6'd1, {16'd0, 4'h0, 12'd8}, 4'hF);
    pulseStart();
    chk("R2", "zero count ignored", {31'b0, busy}, 32'd0);
    regWr(6'd1, {16'd2, 4'h0, 12'd0}, 4'hF);
    pulseStart();
    chk("R2", "zero length ignored", {31'b0, busy}, 32'd0);

    runXfer(32'h0001_0000, 5, 7, 2, 1'b0);          // R4 rounding, 2 beats per block
    runXfer(32'h0007_FFF8, 16, 7, 1, 1'b0);         // R5 512 KiB boundary, R6 same-value resume
    runXfer(32'h0000_2FF4, 12, 0, 2, 1'b1);         // R5 4 KiB, R6 moved resume
    runXfer(32'h0000_0FF0, 8, 0, 2, 1'b0);          // R7 last beat on boundary

    // R9: writes while running are ignored
    regWr(6'd0, 32'h0000_2000, 4'hF);
    regWr(6'd1, {16'd2, 4'h7, 12'd8}, 4'hF);
    pulseStart();
    waitReq("R9");
    regWr(6'd0, 32'hDEAD_0000, 4'hF);
    chk("R9", "addr write ignored while running", memAddr, 32'h0000_2000);
    regWr(6'd1, {16'd9, 4'h0, 12'd40}, 4'hF);
    regRd(6'd1, rd);
    chk("R9", "block write ignored while busy", rd, {16'd2, 4'h7, 12'd8});
    for (int i = 0; i < 4; i++) begin
      chk("R9", "address sequence", memAddr, 32'h0000_2000 + 32'(4 * i));
      ackBeat(0);
    end
    chk("R9", "done after 4 beats", {30'b0, busy, xferDone}, 32'd1);
    regWr(6'd12, 32'h1, 4'h1);

    // R10: software reset mid-transfer keeps registers
    regWr(6'd0, 32'h0000_3000, 4'hF);
    regWr(6'd1, {16'd3, 4'h7, 12'd16}, 4'hF);
    pulseStart();
    ackBeat(0);
    ackBeat(0);
    swReset = 1'b1;
    @(negedge clk);
    swReset = 1'b0;
    chk("R10", "idle after swReset", {28'b0, busy, paused, memReq, xferDone}, 32'd0);
    regRd(6'd0, rd);
    chk("R10", "addr kept", rd, 32'h0000_3008);
    regRd(6'd1, rd);
    chk("R10", "count kept", {16'b0, rd[31:16]}, 32'd3);

    // R10: swReset while paused clears irq
    regWr(6'd0, 32'h0000_0FFC, 4'hF);
    regWr(6'd1, {16'd1, 4'h0, 12'd8}, 4'hF);
    pulseStart();
    ackBeat(0);
    chk("R5", "paused before reset", {30'b0, paused, dmaIrq}, 32'd3);
    swReset = 1'b1;
    @(negedge clk);
    swReset = 1'b0;
    chk("R10", "pause and irq cleared", {29'b0, busy, paused, dmaIrq}, 32'd0);

    for (int t = 0; t < 30; t++) begin
      int field, len, cnt, k;
      logic [31:0] bnd, addr;
      field = $urandom % 8;
      len = 1 + $urandom % 24;
      cnt = 1 + $urandom % 3;
      k = 1 + $urandom % 8;
      bnd = 32'h1000 << field;
      addr = 32'(1 + $urandom % 16) * bnd - 32'(4 * k);
      runXfer(addr, len, field, cnt, 1'($urandom % 2));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule